// File: doc/BRIEF.md
# Transmit Tone Burst Timer

This block decides when the tone synthesizer of a telephone signalling transmitter may produce sound. In burst mode, each write to the transmit data register starts a timed sequence. First comes a tone burst of fixed length. Then comes a silent pause of the same length. When the pause ends, the block emits a one-cycle pulse that sets the transmit-empty status flag. Register decoding and tone synthesis sit outside this block: it consumes a write strobe and mode bits, and it drives a gate and a set pulse.

Both phases are counted in reference-clock cycles. The default `BURST_CYCLES` is 182,557, which gives about 51 ms at a 3.579545 MHz clock. When call-progress mode is selected, each phase lasts twice as long. The choice of length is captured at the moment a burst starts.

The burst-disable input is active high. While it is asserted, the gate follows the tone-enable bit directly and the sequencer stays idle. The tone-enable bit masks the gate in every mode, but it does not stop the timer.

Top module: `tone_burst_sequencer`

## Requirements
- R1: In burst mode, a write sampled at clock edge k makes `tone_gate` high for exactly `BURST_CYCLES` cycles, starting right after edge k, provided `tone_en` is high.
- R2: The silent pause following a burst lasts `BURST_CYCLES` cycles. `tx_empty_set` then pulses in the cycle after edge k+2·`BURST_CYCLES`.
- R3: If `cp_mode` is high at the edge that starts a burst, both the burst and the pause last 2·`BURST_CYCLES` cycles. A change of `cp_mode` after that edge does not alter the running sequence.
- R4: `tx_empty_set` is high for exactly one cycle per finished sequence, and never at any other time.
- R5: With `tone_en` low, `tone_gate` stays low, but the burst and pause timing still runs and the set pulse still appears on schedule.
- R6: While `burst_off` is high, `tone_gate` equals `tone_en`. Writes start nothing and are not queued, and no set pulse is produced.
- R7: A write during a burst or pause does not restart the timing. It is held, and the next burst starts right after the pause ends. No set pulse is given between the two sequences.
- R8: Raising `burst_off` during a sequence aborts it and discards any held write. After `burst_off` falls again, the block stays idle with no pulse until a new write arrives.
- R9: During and right after reset, the block is idle: `tx_empty_set` is low, and `tone_gate` is low when in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One-cycle strobe for a transmit data write |
| burst_off | input | 1 | High disables burst timing |
| cp_mode | input | 1 | Call-progress mode; doubles both phase lengths |
| tone_en | input | 1 | Tone-output enable; masks the gate in every mode |
| tone_gate | output | 1 | Enables the tone synthesizer |
| tx_empty_set | output | 1 | One-cycle pulse that sets the transmit-empty flag |

## Verification
The bench builds the block with `BURST_CYCLES` = 4. With this value, a normal sequence lasts 8 cycles and an extended sequence lasts 16 cycles. Every phase boundary, pulse position and doubled length can therefore be checked cycle by cycle. This short length also lets the bench land a second write inside a particular phase, and raise the disable input in the middle of a burst, within a few cycles.

// File: rtl/tone_burst_sequencer.sv
module tone_burst_sequencer #(
  parameter int unsigned BURST_CYCLES = 182557
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic burst_off,
  input  logic cp_mode,
  input  logic tone_en,
  output logic tone_gate,
  output logic tx_empty_set
);

  localparam int unsigned CW = $clog2(2 * BURST_CYCLES);
  localparam logic [CW-1:0] LEN_N = CW'(BURST_CYCLES - 1);
  localparam logic [CW-1:0] LEN_X = CW'(2 * BURST_CYCLES - 1);

  typedef enum logic [1:0] {IDLE, BURST, PAUSE} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          ext_q;
  logic          pend_q;

  wire           done      = (cnt == '0);
  wire [CW-1:0]  start_len = cp_mode ? LEN_X : LEN_N;
  wire [CW-1:0]  reload    = ext_q ? LEN_X : LEN_N;

  assign tone_gate = tone_en & (burst_off | (ph == BURST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph           <= IDLE;
      cnt          <= '0;
      ext_q        <= 1'b0;
      pend_q       <= 1'b0;
      tx_empty_set <= 1'b0;
    end else begin
      tx_empty_set <= 1'b0;
      if (burst_off) begin
        ph     <= IDLE;
        cnt    <= '0;
        pend_q <= 1'b0;
      end else begin
        case (ph)
          IDLE: begin
            if (wr_stb) begin
              ph    <= BURST;
              cnt   <= start_len;
              ext_q <= cp_mode;
            end
          end
          BURST: begin
            if (wr_stb) pend_q <= 1'b1;
            if (done) begin
              ph  <= PAUSE;
              cnt <= reload;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          PAUSE: begin
            if (done) begin
              if (pend_q || wr_stb) begin
                ph     <= BURST;
                cnt    <= start_len;
                ext_q  <= cp_mode;
                pend_q <= 1'b0;
              end else begin
                ph           <= IDLE;
                tx_empty_set <= 1'b1;
              end
            end else begin
              cnt <= cnt - 1'b1;
              if (wr_stb) pend_q <= 1'b1;
            end
          end
          default: ph <= IDLE;
        endcase
      end
    end
  end

  // R4
  set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_set |=> !tx_empty_set);

  // R2
  set_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_set |-> $past(ph) == PAUSE);

  // R6
  no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_off && $past(burst_off)) |-> !tx_empty_set);

  // R5
  gate_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_gate |-> tone_en);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != IDLE && !done && !burst_off) |=> cnt == CW'($past(cnt) - 1'b1));

endmodule

// File: tb/tb_tone_burst_sequencer.sv
module tb_tone_burst_sequencer;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic burst_off = 1'b0;
  logic cp_mode = 1'b0;
  logic tone_en = 1'b1;
  logic tone_gate, tx_empty_set;

  int n_chk = 0;
  int n_fail = 0;
  logic g [0:63];
  logic p [0:63];
  int idx = 0;
  logic rec = 1'b0;

  tone_burst_sequencer #(.BURST_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .burst_off(burst_off),
    .cp_mode(cp_mode), .tone_en(tone_en),
    .tone_gate(tone_gate), .tx_empty_set(tx_empty_set)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (rec && idx < 64) begin
      g[idx] = tone_gate;
      p[idx] = tx_empty_set;
      idx = idx + 1;
    end
  end

  // each row: cp_mode, tone_en, expected gate-high cycles, expected pulse index
  localparam int VEC [0:3][0:3] = '{
    '{0, 1, N,     2*N},
    '{1, 1, 2*N,   4*N},
    '{0, 0, 0,     2*N},
    '{1, 0, 0,     4*N}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_write(input logic cp, input logic ten);
    @(negedge clk);
    cp_mode = cp;
    tone_en = ten;
    wr_stb = 1'b1;
    idx = 0;
    rec = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_idx(input int n);
    while (idx < n) @(negedge clk);
  endtask

  function automatic int gate_count(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (g[i]) c++;
    return c;
  endfunction

  function automatic int pulse_count(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (p[i]) c++;
    return c;
  endfunction

  function automatic int pulse_at(input int n);
    for (int i = 0; i < n; i++) if (p[i]) return i;
    return -1;
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check(tone_gate == 1'b0, "R9 gate in reset", tone_gate, 0);
    check(tx_empty_set == 1'b0, "R9 pulse in reset", tx_empty_set, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tone_gate == 1'b0 && tx_empty_set == 1'b0, "R9 idle after reset",
          {tone_gate, tx_empty_set}, 0);

    // R1 R2 R3 R5 vector table
    for (int v = 0; v < 4; v++) begin
      start_write(VEC[v][0][0], VEC[v][1][0]);
      wait_idx(4*N + 6);
      check(gate_count(4*N + 6) == VEC[v][2], "R1/R3/R5 gate length",
            gate_count(4*N + 6), VEC[v][2]);
      check(pulse_at(4*N + 6) == VEC[v][3], "R2/R3 pulse position",
            pulse_at(4*N + 6), VEC[v][3]);
      check(pulse_count(4*N + 6) == 1, "R4 single pulse", pulse_count(4*N + 6), 1);
      if (VEC[v][1] != 0)
        check(g[0] == 1'b1, "R1 gate starts after write edge", g[0], 1);
      rec = 1'b0;
    end

    // R3 cp_mode change mid-burst does not alter length
    start_write(1'b1, 1'b1);
    cp_mode = 1'b0;
    wait_idx(4*N + 6);
    check(gate_count(4*N + 6) == 2*N, "R3 latched length", gate_count(4*N + 6), 2*N);
    check(pulse_at(4*N + 6) == 4*N, "R3 latched pulse", pulse_at(4*N + 6), 4*N);
    rec = 1'b0;

    // R7 write during burst is held, no restart
    start_write(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    wait_idx(4*N + 6);
    check(g[N] == 1'b0, "R7 burst not restarted", g[N], 0);
    check(g[2*N] == 1'b1, "R7 held write starts next burst", g[2*N], 1);
    check(gate_count(4*N + 6) == 2*N, "R7 two bursts", gate_count(4*N + 6), 2*N);
    check(pulse_count(4*N + 6) == 1 && pulse_at(4*N + 6) == 4*N, "R7 one pulse at end",
          pulse_at(4*N + 6), 4*N);
    rec = 1'b0;

    // R8 abort mid-burst discards held write
    start_write(1'b0, 1'b1);
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    burst_off = 1'b1;
    @(negedge clk);
    tone_en = 1'b0;
    @(negedge clk);
    burst_off = 1'b0;
    tone_en = 1'b1;
    wait_idx(4*N + 6);
    check(pulse_count(4*N + 6) == 0, "R8 no pulse after abort", pulse_count(4*N + 6), 0);
    check(g[2*N] == 1'b0 && g[4*N] == 1'b0, "R8 stays idle", g[2*N], 0);
    rec = 1'b0;

    // R6 burst disabled: gate follows tone_en, writes ignored
    @(negedge clk);
    burst_off = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tone_en = i[0];
      wr_stb = (i < 3);
      #2;
      check(tone_gate == tone_en, "R6 gate follows enable", tone_gate, tone_en);
      @(negedge clk);
      check(tx_empty_set == 1'b0, "R6 no pulse", tx_empty_set, 0);
    end
    wr_stb = 1'b0;
    tone_en = 1'b1;
    burst_off = 1'b0;
    idx = 0;
    rec = 1'b1;
    wait_idx(4*N);
    check(gate_count(4*N) == 0 && pulse_count(4*N) == 0, "R6 writes not queued",
          gate_count(4*N), 0);
    rec = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule